// File: doc/BRIEF.md
# Flash Sector Write-Protection Unit

This block sits between a serial flash command decoder and the flash array. It decides whether a program or erase aimed at a byte address may go ahead. It combines two independent protection schemes. The first is a per-sector lock register that holds a write-lock bit and a sticky lock-down bit. The second is a contiguous block-protect range, chosen by a 3-bit size code and a top/bottom select that are held in the status register.

Commands arrive as a single-cycle strobe with a 2-bit opcode, a 22-bit byte address and an 8-bit data byte. The status register also carries a write-disable bit. While that bit is set and the hardware write-protect pin is held low, status writes are refused. Each command is answered one cycle later by a response strobe. That cycle also carries the allow flag for checks and an error pulse for any refused write.

Top module: `sect_guard`

## Requirements
- R1: After the power-up reset `rst`, every sector's write-lock and lock-down bits read 0, `stat_rdata` reads 0x00, and `rsp_valid`, `chk_allow` and `err` are 0.
- R2: The sector index is `addr[21:16]`, which gives 64 sectors of 64 KB. Opcode 1 (lock write) stores `wdata[0]` as write-lock and `wdata[1]` as lock-down. Opcode 0 (lock read) places {lock-down, write-lock} on `lock_rdata[1:0]` in the cycle after the command.
- R3: Opcode 3 (check) gives `chk_allow`=0 in the response cycle when the addressed sector's write-lock bit is 1. Otherwise, outside any block-protect range, it gives 1.
- R4: A lock write to a sector whose lock-down bit is 1 changes neither of its bits and raises `err` for one cycle. Other sectors stay writable.
- R5: Only `rst` clears a lock-down bit. After a reset the sector accepts lock writes again.
- R6: Opcode 2 (status write) loads write-disable from `wdata[7]`, top/bottom from `wdata[4]` and the block-protect code from `wdata[2:0]`. `stat_rdata` shows the same positions, and its other bits read 0.
- R7: When write-disable is 1 and `wp_n` is 0, a status write is refused: the status is unchanged and `err` pulses. When `wp_n` is 1, the write succeeds even though write-disable is set.
- R8: With block-protect code B>0 and top/bottom 0, the 2^(B-1) highest sectors (ending at sector 63) are denied. Code 0 protects nothing.
- R9: With top/bottom 1, the 2^(B-1) lowest sectors (starting at sector 0) are denied. Code 7 denies every sector.
- R10: `rsp_valid` is 1 exactly in the cycle after each command. `chk_allow` is 0 for any non-check command, and `err` is 0 for accepted commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 lock read, 1 lock write, 2 status write, 3 check |
| addr | input | 22 | Byte address |
| wdata | input | 8 | Write data for lock or status writes |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| rsp_valid | output | 1 | Response strobe, one cycle after a command |
| lock_rdata | output | 2 | {lock-down, write-lock} of the last sector read |
| stat_rdata | output | 8 | Status register image |
| chk_allow | output | 1 | Program/erase permitted (check responses) |
| err | output | 1 | Refused lock or status write |

## Verification
The hardest states to reach are those that persist until power-up. Examples are a locked-down sector, and a status register frozen by write-disable together with a low pin. Any mistake in these states is visible only through later refused commands. The bench first sets lock-down and write-disable. It then sends writes that should bounce off, and reads the state back through the lock-read path and the status output. Finally it pulses reset mid-run and shows that the sector becomes writable again.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    OP_RLOCK = 2'd0,
    OP_WLOCK = 2'd1,
    OP_WSTAT = 2'd2,
    OP_CHECK = 2'd3
  } sg_op_e;

  localparam int BP_W     = 3;
  localparam int ST_SRWD  = 7;
  localparam int ST_TB    = 4;
  localparam int LK_WL    = 0;
  localparam int LK_LD    = 1;
endpackage

// File: rtl/sg_lock_bank.sv
module sg_lock_bank #(
  parameter int SECT_W   = 6,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SECT_W-1:0]   sect,
  input  logic                we,
  input  logic                re,
  input  logic [1:0]          wbits,
  output logic                rej,
  output logic [1:0]          rd_q,
  output logic [NUM_SECT-1:0] wl_vec,
  output logic [NUM_SECT-1:0] ld_vec
);
  logic [1:0] bits_q [NUM_SECT];

  assign rej = we & bits_q[sect][sg_pkg::LK_LD];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SECT; i++) bits_q[i] <= 2'b00;
      rd_q <= 2'b00;
    end else begin
      if (we && !bits_q[sect][sg_pkg::LK_LD]) bits_q[sect] <= wbits;
      if (re) rd_q <= bits_q[sect];
    end
  end

  for (genvar g = 0; g < NUM_SECT; g++) begin : g_vec
    assign wl_vec[g] = bits_q[g][sg_pkg::LK_WL];
    assign ld_vec[g] = bits_q[g][sg_pkg::LK_LD];
  end
endmodule

// File: rtl/sg_status_reg.sv
module sg_status_reg (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [7:0]            wdata,
  input  logic                  wp_n,
  output logic                  rej,
  output logic                  srwd,
  output logic                  tb,
  output logic [sg_pkg::BP_W-1:0] bp
);
  logic frozen;
  logic unused_bits;

  assign frozen      = srwd & ~wp_n;
  assign rej         = we & frozen;
  assign unused_bits = ^{wdata[6:5], wdata[3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      srwd <= 1'b0;
      tb   <= 1'b0;
      bp   <= '0;
    end else if (we && !frozen) begin
      srwd <= wdata[sg_pkg::ST_SRWD];
      tb   <= wdata[sg_pkg::ST_TB];
      bp   <= wdata[sg_pkg::BP_W-1:0];
    end
  end
endmodule

// File: rtl/sg_range_decode.sv
module sg_range_decode #(
  parameter int SECT_W   = 6,
  localparam int NUM_SECT = 1 << SECT_W,
  localparam int CNT_W    = SECT_W + 2
) (
  input  logic [sg_pkg::BP_W-1:0] bp,
  input  logic                    tb,
  input  logic [SECT_W-1:0]       sect,
  output logic                    hit
);
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] idx;

  assign idx = CNT_W'(sect);

  always_comb begin
    if (bp == '0) span = '0;
    else          span = CNT_W'(1) << (bp - 1'b1);
    if (span > CNT_W'(NUM_SECT)) span = CNT_W'(NUM_SECT);
    if (tb) hit = (idx < span);
    else    hit = (idx >= (CNT_W'(NUM_SECT) - span));
  end
endmodule

// File: rtl/sect_guard.sv
module sect_guard #(
  parameter int ADDR_W = 22,
  parameter int SECT_LG = 16,
  localparam int SECT_W = ADDR_W - SECT_LG,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wp_n,
  output logic              rsp_valid,
  output logic [1:0]        lock_rdata,
  output logic [7:0]        stat_rdata,
  output logic              chk_allow,
  output logic              err
);
  import sg_pkg::*;

  logic [SECT_W-1:0]   sect;
  logic                is_rl, is_wl, is_ws, is_ck;
  logic                lk_rej, st_rej, range_hit;
  logic                srwd, tb;
  logic [BP_W-1:0]     bp;
  logic [NUM_SECT-1:0] wl_vec, ld_vec;
  logic                unused_addr;

  assign sect        = addr[ADDR_W-1:SECT_LG];
  assign unused_addr = ^addr[SECT_LG-1:0];
  assign is_rl = cmd_valid && (cmd_op == OP_RLOCK);
  assign is_wl = cmd_valid && (cmd_op == OP_WLOCK);
  assign is_ws = cmd_valid && (cmd_op == OP_WSTAT);
  assign is_ck = cmd_valid && (cmd_op == OP_CHECK);

  sg_lock_bank #(.SECT_W(SECT_W)) u_bank (
    .clk(clk), .rst(rst), .sect(sect), .we(is_wl), .re(is_rl),
    .wbits(wdata[1:0]), .rej(lk_rej), .rd_q(lock_rdata),
    .wl_vec(wl_vec), .ld_vec(ld_vec)
  );

  sg_status_reg u_stat (
    .clk(clk), .rst(rst), .we(is_ws), .wdata(wdata), .wp_n(wp_n),
    .rej(st_rej), .srwd(srwd), .tb(tb), .bp(bp)
  );

  sg_range_decode #(.SECT_W(SECT_W)) u_range (
    .bp(bp), .tb(tb), .sect(sect), .hit(range_hit)
  );

  always_comb begin
    stat_rdata          = '0;
    stat_rdata[ST_SRWD] = srwd;
    stat_rdata[ST_TB]   = tb;
    stat_rdata[BP_W-1:0] = bp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      chk_allow <= 1'b0;
      err       <= 1'b0;
    end else begin
      rsp_valid <= cmd_valid;
      chk_allow <= is_ck && !wl_vec[sect] && !range_hit;
      err       <= lk_rej || st_rej;
    end
  end
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int SECT_W = 6,
  localparam int NUM_SECT = 1 << SECT_W
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_valid,
  input logic [1:0]          cmd_op,
  input logic [SECT_W-1:0]   sect,
  input logic                wp_n,
  input logic [NUM_SECT-1:0] wl_vec,
  input logic [NUM_SECT-1:0] ld_vec,
  input logic [7:0]          stat_rdata,
  input logic                rsp_valid,
  input logic                chk_allow,
  input logic                err
);
  assert_deny_wl_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd3 && wl_vec[sect]) |=> !chk_allow);

  assert_ld_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ld_vec & $past(ld_vec)) == $past(ld_vec)));

  assert_ld_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((wl_vec ^ $past(wl_vec)) & $past(ld_vec)) == '0));

  assert_stat_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2 && stat_rdata[7] && !wp_n) |=> (err && $stable(stat_rdata)));

  assert_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid);

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> (!rsp_valid && !err && !chk_allow));
endmodule

bind sect_guard sg_checker #(.SECT_W(SECT_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .sect(sect),
  .wp_n(wp_n), .wl_vec(wl_vec), .ld_vec(ld_vec), .stat_rdata(stat_rdata),
  .rsp_valid(rsp_valid), .chk_allow(chk_allow), .err(err)
);

// File: tb/sect_guard_bench.sv
module sect_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [21:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wp_n = 1'b1;
  logic        rsp_valid, chk_allow, err;
  logic [1:0]  lock_rdata;
  logic [7:0]  stat_rdata;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  sect_guard u_sect_guard (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .addr(addr),
    .wdata(wdata), .wp_n(wp_n), .rsp_valid(rsp_valid), .lock_rdata(lock_rdata),
    .stat_rdata(stat_rdata), .chk_allow(chk_allow), .err(err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input int sec, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    addr = {sec[5:0], 16'h1234}; wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic expect_lock(input string req, input int sec, input int exp);
    cmd(2'd0, sec, 8'h00);
    check(req, lock_rdata, exp);
  endtask

  task automatic expect_allow(input string req, input int sec, input bit exp);
    cmd(2'd3, sec, 8'h00);
    check({req, " rsp"}, rsp_valid, 1);
    check(req, chk_allow, exp);
  endtask

  task automatic t_reset();
    check("R1 rsp", rsp_valid, 0);
    check("R1 allow", chk_allow, 0);
    check("R1 err", err, 0);
    check("R1 stat", stat_rdata, 8'h00);
    expect_lock("R1 lock", 5, 0);
    expect_lock("R1 lock63", 63, 0);
  endtask

  task automatic t_wlock();
    cmd(2'd1, 10, 8'hFD);
    check("R10 err accepted", err, 0);
    check("R10 no allow", chk_allow, 0);
    expect_lock("R2 readback", 10, 1);
    expect_lock("R2 neighbour", 11, 0);
    expect_allow("R3 denied", 10, 0);
    expect_allow("R3 allowed", 11, 1);
    cmd(2'd1, 10, 8'h00);
    expect_allow("R3 unlocked", 10, 1);
    @(negedge clk);
    check("R10 idle", rsp_valid, 0);
  endtask

  task automatic t_lockdown();
    cmd(2'd1, 20, 8'h03);
    check("R4 first ok", err, 0);
    cmd(2'd1, 20, 8'h00);
    check("R4 err", err, 1);
    @(negedge clk);
    check("R4 err one cycle", err, 0);
    expect_lock("R4 unchanged", 20, 3);
    expect_allow("R4 still denied", 20, 0);
    cmd(2'd1, 21, 8'h01);
    check("R4 other ok", err, 0);
    expect_lock("R4 other", 21, 1);
  endtask

  task automatic t_status();
    cmd(2'd2, 0, 8'hFF);
    check("R6 map", stat_rdata, 8'h97);
    expect_allow("R9 bp7 all", 40, 0);
    cmd(2'd2, 0, 8'h03);
    check("R6 stat", stat_rdata, 8'h03);
    expect_allow("R8 top in", 60, 0);
    expect_allow("R8 top edge", 59, 1);
    expect_allow("R8 bottom free", 0, 1);
    cmd(2'd2, 0, 8'h13);
    expect_allow("R9 bottom in", 3, 0);
    expect_allow("R9 bottom edge", 4, 1);
    cmd(2'd2, 0, 8'h01);
    expect_allow("R8 bp1 top", 63, 0);
    expect_allow("R8 bp1 62", 62, 1);
    cmd(2'd2, 0, 8'h00);
    expect_allow("R8 bp0", 63, 1);
  endtask

  task automatic t_freeze();
    cmd(2'd2, 0, 8'h80);
    check("R7 set srwd", stat_rdata, 8'h80);
    wp_n = 1'b0;
    cmd(2'd2, 0, 8'h05);
    check("R7 err", err, 1);
    check("R7 frozen", stat_rdata, 8'h80);
    wp_n = 1'b1;
    cmd(2'd2, 0, 8'h05);
    check("R7 pin high err", err, 0);
    check("R7 pin high", stat_rdata, 8'h05);
    wp_n = 1'b0;
    cmd(2'd2, 0, 8'h00);
    check("R7 srwd clear ok", stat_rdata, 8'h00);
    wp_n = 1'b1;
  endtask

  task automatic t_powerup();
    do_reset();
    expect_lock("R5 cleared", 20, 0);
    cmd(2'd1, 20, 8'h01);
    check("R5 writable err", err, 0);
    expect_lock("R5 writable", 20, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_wlock();
    t_lockdown();
    t_status();
    t_freeze();
    t_powerup();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule